// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer with APB Access

A bank of independent down-counters behind an APB slave port. Each channel counts down by one on every clock while it is enabled. When it reaches zero it reloads and records an interrupt event. It can reload either the all-ones value (free running) or the count that software programmed (periodic). Each channel has its own interrupt line, and that line can be masked per channel.

Software programs a channel as follows: while the channel is stopped, write the reload value, then write the control word with the enable bit set. It services interrupts by reading an end-of-interrupt location. Reading the per-channel location acknowledges one channel; reading the shared location acknowledges every channel at once. Shared locations also give a vector of masked status, a vector of raw status and a fixed version word. The bus never inserts wait states and never signals an error. Read data is driven combinationally from registered state during the access phase.

Top module: `tmr_bank`

## Requirements
- R1: Channel n occupies byte addresses 20n to 20n+19, with offsets 0 = reload value, 4 = current count (read-only), 8 = control, 12 = end-of-interrupt, 16 = status. The shared words are 0xA0 masked vector, 0xA4 global end-of-interrupt, 0xA8 raw vector and 0xAC version (parameter VERSION). Any other address reads 0.
- R2: Control bit 0 is enable, bit 1 is periodic (1) or free running (0), and bit 2 is interrupt mask. Control reads back bits [2:0] as written and reads 0 above them.
- R3: A control write that sets enable on a stopped channel loads the count from the reload value at that clock edge. After that the count drops by exactly one per clock.
- R4: A stopped channel holds its count and records no event.
- R5: In free-running mode, an enabled channel whose count is 0 at a clock edge reloads 0xFFFFFFFF and records an event.
- R6: In periodic mode the count reloads the programmed value at zero, so the period is value+1 clocks. A reload-value write made while the channel runs takes effect at the next reload.
- R7: Raw vector bit n records channel n's pending event regardless of the mask. irq[n], masked-vector bit n and the channel status bit 0 all equal raw AND NOT mask.
- R8: A read of a channel's end-of-interrupt word returns 0 and clears that channel's pending event. A read of 0xA4 returns 0 and clears all channels.
- R9: An event and an end-of-interrupt read in the same clock leave the event pending.
- R10: pready is always 1 and pslverr is always 0; every transfer completes in its first access cycle.
- R11: Synchronous reset clears all reload values, counts, controls and pending events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | AW | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| irq | output | N_CH | Per-channel masked interrupt |

## Verification
The in-RTL properties check the counting rules on every cycle. These are the hold while stopped, the single-step decrement, the load on a start, the all-ones versus programmed reload, and event capture at zero. They also check that an acknowledgement clears a pending event unless a new event lands in the same cycle. What the properties cannot show is the address map as software sees it. That covers control read-back masking, zero for unmapped addresses, and a reload written mid-run that only appears after the next wrap. It also covers an acknowledgement that really coincides with a terminal count. The bench's cycle-accurate model exposes these by comparing every read and every interrupt line across scripted scenarios.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int STRIDE   = 20;
  localparam int OFF_LOAD = 0;
  localparam int OFF_CUR  = 4;
  localparam int OFF_CTRL = 8;
  localparam int OFF_EOI  = 12;
  localparam int OFF_STAT = 16;
  localparam int SH_MSTAT = 'hA0;
  localparam int SH_GEOI  = 'hA4;
  localparam int SH_RAW   = 'hA8;
  localparam int SH_VER   = 'hAC;

  // bit 2 mask, bit 1 periodic, bit 0 enable
  typedef struct packed {
    logic mask;
    logic periodic;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int N_CH = 4,
  parameter int AW   = 8
) (
  input  logic [AW-1:0]   addr,
  output logic [N_CH-1:0] hit,
  output logic [4:0]      off
);
  always_comb begin
    hit = '0;
    off = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (int'(addr) >= i * STRIDE && int'(addr) < (i + 1) * STRIDE) begin
        hit[i] = 1'b1;
        off    = 5'(int'(addr) - i * STRIDE);
      end
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_load,
  input  logic          wr_ctrl,
  input  logic [31:0]   wdata,
  input  logic          eoi,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] load,
  output ctrl_t         ctrl,
  output logic          raw,
  output logic          tc
);
  logic [CW-1:0] cnt_q, load_q;
  ctrl_t         ctrl_q;
  logic          raw_q;
  logic          start;

  assign start = wr_ctrl && !ctrl_q.en && wdata[0];
  assign tc    = ctrl_q.en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      load_q <= '0;
      ctrl_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata[CW-1:0];
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[2:0]);
      if (start)             cnt_q <= load_q;
      else if (tc)           cnt_q <= ctrl_q.periodic ? load_q : '1;
      else if (ctrl_q.en)    cnt_q <= cnt_q - CW'(1);
      if (tc)                raw_q <= 1'b1;
      else if (eoi)          raw_q <= 1'b0;
    end
  end

  assign cnt  = cnt_q;
  assign load = load_q;
  assign ctrl = ctrl_q;
  assign raw  = raw_q;

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.en && !start) |=> $stable(cnt_q));
  assert_noevt_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.en && !raw_q) |=> !raw_q);
  assert_start_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == $past(load_q)));
  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  assert_free_R5: assert property (@(posedge clk) disable iff (rst)
    (tc && !ctrl_q.periodic) |=> (cnt_q == '1));
  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    (tc && ctrl_q.periodic) |=> (cnt_q == $past(load_q)));
  assert_keep_R9: assert property (@(posedge clk) disable iff (rst)
    tc |=> raw_q);
  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (eoi && !tc) |=> !raw_q);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int          N_CH    = 4,
  parameter int          CW      = 32,
  parameter int          AW      = 8,
  parameter logic [31:0] VERSION = 32'h0102_0A00
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [31:0]     pwdata,
  output logic [31:0]     prdata,
  output logic            pready,
  output logic            pslverr,
  output logic [N_CH-1:0] irq
);
  logic            acc, wr, rd, geoi;
  logic [N_CH-1:0] hit, raw_v, tc_v, mask_v, eoi_v;
  logic [4:0]      off;
  logic [CW-1:0]   cnt_v  [N_CH];
  logic [CW-1:0]   load_v [N_CH];
  ctrl_t           ctrl_v [N_CH];

  assign acc  = psel && penable;
  assign wr   = acc && pwrite;
  assign rd   = acc && !pwrite;
  assign geoi = rd && (int'(paddr) == SH_GEOI);

  tmr_addr_dec #(.N_CH(N_CH), .AW(AW)) u_dec (
    .addr(paddr), .hit(hit), .off(off)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign eoi_v[g] = geoi || (rd && hit[g] && int'(off) == OFF_EOI);
    tmr_channel #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst),
      .wr_load(wr && hit[g] && int'(off) == OFF_LOAD),
      .wr_ctrl(wr && hit[g] && int'(off) == OFF_CTRL),
      .wdata(pwdata), .eoi(eoi_v[g]),
      .cnt(cnt_v[g]), .load(load_v[g]), .ctrl(ctrl_v[g]),
      .raw(raw_v[g]), .tc(tc_v[g])
    );
    assign mask_v[g] = ctrl_v[g].mask;
  end

  assign irq     = raw_v & ~mask_v;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_comb begin
    prdata = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (hit[i]) begin
        case (int'(off))
          OFF_LOAD: prdata = 32'(load_v[i]);
          OFF_CUR:  prdata = 32'(cnt_v[i]);
          OFF_CTRL: prdata = 32'(ctrl_v[i]);
          OFF_STAT: prdata = {31'b0, irq[i]};
          default:  ;
        endcase
      end
    end
    case (int'(paddr))
      SH_MSTAT: prdata = 32'(irq);
      SH_RAW:   prdata = 32'(raw_v);
      SH_VER:   prdata = VERSION;
      default:  ;
    endcase
  end

  assert_geoi_R8: assert property (@(posedge clk) disable iff (rst)
    geoi |=> ((raw_v & ~$past(tc_v)) == '0));
  assert_eoi_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && eoi_v != '0) |-> (prdata == '0));
  assert_record_R7: assert property (@(posedge clk) disable iff (rst)
    (tc_v != '0) |=> ((raw_v & $past(tc_v)) == $past(tc_v)));
endmodule

// File: tb/sim_tmr_bank.sv
`timescale 1ns/100ps
module sim_tmr_bank;
  localparam int NCH = 4;
  localparam logic [31:0] VER = 32'h0102_0A00;

  logic clk = 0, rst = 1;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0;
  logic [31:0] prdata;
  logic pready, pslverr;
  logic [NCH-1:0] irq;

  int ntests = 0, nfail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_bank #(.N_CH(NCH), .CW(32), .AW(8), .VERSION(VER)) u0 (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_load [NCH];
  logic [31:0] m_cnt  [NCH];
  logic [2:0]  m_ctrl [NCH];
  logic        m_raw  [NCH];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_load[i] = 0; m_cnt[i] = 0; m_ctrl[i] = 0; m_raw[i] = 0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        int b, o;
        bit h, st, tcv, clr;
        b = i * 20; o = int'(paddr) - b;
        h = psel && penable && int'(paddr) >= b && int'(paddr) < b + 20;
        st  = h && pwrite && o == 8 && !m_ctrl[i][0] && pwdata[0];
        tcv = m_ctrl[i][0] && m_cnt[i] == 0;
        clr = psel && penable && !pwrite && ((h && o == 12) || paddr == 8'hA4);
        if (st) m_cnt[i] = m_load[i];
        else if (m_ctrl[i][0])
          m_cnt[i] = (m_cnt[i] == 0) ? (m_ctrl[i][1] ? m_load[i] : 32'hFFFF_FFFF)
                                     : m_cnt[i] - 1;
        if (tcv) m_raw[i] = 1;
        else if (clr) m_raw[i] = 0;
        if (h && pwrite && o == 8) m_ctrl[i] = pwdata[2:0];
        if (h && pwrite && o == 0) m_load[i] = pwdata;
      end
    end
  end

  function automatic logic [NCH-1:0] m_irq();
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) v[i] = m_raw[i] && !m_ctrl[i][2];
    return v;
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [NCH-1:0] rv;
    for (int i = 0; i < NCH; i++) rv[i] = m_raw[i];
    for (int i = 0; i < NCH; i++) begin
      if (int'(a) >= i * 20 && int'(a) < i * 20 + 20) begin
        case (int'(a) - i * 20)
          0: return m_load[i];
          4: return m_cnt[i];
          8: return {29'b0, m_ctrl[i]};
          16: return {31'b0, m_raw[i] && !m_ctrl[i][2]};
          default: return 0;
        endcase
      end
    end
    case (a)
      8'hA0: return 32'(m_irq());
      8'hA8: return 32'(rv);
      8'hAC: return VER;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle compare away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(irq == m_irq(), "R7 irq", 32'(irq), 32'(m_irq()));
      chk(pready == 1'b1 && pslverr == 1'b0, "R10 handshake", {30'b0, pready, pslverr}, 32'h2);
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1; #1;
    e = m_read(a);
    chk(prdata === e, tag, prdata, e);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      nfail++; ntests++;
      $display("FAIL watchdog actual=%0d expected<50000", cyc);
      $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R11 reset state
    bus_rd(8'h00, "R11 load");
    bus_rd(8'h04, "R11 count");
    bus_rd(8'h08, "R11 ctrl");
    bus_rd(8'h10, "R11 status");
    bus_rd(8'hA0, "R11 masked");
    bus_rd(8'hA8, "R11 raw");
    // R1 map
    bus_rd(8'hAC, "R1 version");
    bus_rd(8'h50, "R1 unmapped");
    bus_rd(8'hB0, "R1 unmapped");
    bus_rd(8'h4F, "R1 hole");
    // R2 control fields
    bus_wr(8'h08, 32'h6);
    bus_rd(8'h08, "R2 readback");
    bus_wr(8'h08, 32'hFFFF_FFF8);
    bus_rd(8'h08, "R2 upper bits");
    // R3/R5 free run on channel 0
    bus_wr(8'h00, 32'd5);
    bus_wr(8'h08, 32'h1);
    bus_rd(8'h04, "R3 count");
    bus_rd(8'h04, "R3 count");
    idle(3);
    bus_rd(8'h04, "R5 wrap");
    bus_rd(8'h10, "R7 status");
    bus_rd(8'hA0, "R7 masked");
    // R6/R7 periodic masked channel 1
    bus_wr(8'd20, 32'd3);
    bus_wr(8'd28, 32'h7);
    idle(20);
    bus_rd(8'hA8, "R7 raw");
    bus_rd(8'hA0, "R7 masked");
    bus_rd(8'd36, "R7 masked status");
    bus_rd(8'd24, "R6 count");
    bus_rd(8'd24, "R6 count");
    // R8 channel acknowledge
    bus_rd(8'h0C, "R8 eoi zero");
    bus_rd(8'hA8, "R8 raw after eoi");
    // R6 reload written while running
    bus_wr(8'd20, 32'd9);
    bus_rd(8'd24, "R6 old period");
    idle(30);
    bus_rd(8'd24, "R6 new period");
    bus_rd(8'd24, "R6 new period");
    // R9 collisions on channel 2 (period 4, accesses every 3 cycles)
    bus_wr(8'd40, 32'd3);
    bus_wr(8'd48, 32'h3);
    for (int k = 0; k < 12; k++) begin
      bus_rd(8'd52, "R9 eoi");
      bus_rd(8'd56, "R9 status");
    end
    // R8 global acknowledge
    bus_rd(8'hA4, "R8 global eoi");
    bus_rd(8'hA8, "R8 raw after global");
    // R4 stop channel 1 and hold
    bus_wr(8'd28, 32'h6);
    bus_rd(8'hA4, "R8 global eoi");
    bus_rd(8'd24, "R4 held");
    idle(10);
    bus_rd(8'd24, "R4 held");
    bus_rd(8'hA8, "R4 no event");
    idle(5);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule